// File: doc/BRIEF.md
# Six-Leg Rectified-Current PI Regulator

This block closes the inner current loop of a three-phase boost rectifier built from two interleaved converters, giving six legs in all. Once per control period a start strobe latches six signed leg-current samples, the peak-current command from the outer voltage loop, a constant equal to half the DC output reference, the largest filtered input-voltage magnitude and the midpoint (upper minus lower capacitor) voltage error. The block then updates every leg in turn and returns six duty words. Each leg has its own proportional-integral regulator in the per-phase frame. The regulator acts on the magnitude of the leg current.

The reference for each leg is the peak command times a rectified-sine shape. This shape does not come from a measured phase voltage. An observer rebuilds it from the leg's own previous duty: half the DC reference times (1 − previous duty), divided by the maximum input voltage. A shared restoring divider runs this division one leg at a time. A proportional midpoint-balance term is added to all six legs alike. Each duty is clamped just below one, so the (1 − D) factor that the next period uses stays positive. The integrator stops accumulating while its leg's output is clamped.

Top module: `leg_current_pi`

## Requirements
- R1: A synchronous reset clears all six integrators, forces every duty word to zero and holds done low. The first period after reset with zero error and zero midpoint error returns zero duties.
- R2: Each leg's shape is min(2^W, floor(vhalf·(2^W − Dprev)/vmax)), in units of 2^-W. Dprev is that leg's duty from the previous period (zero after reset). A zero vmax yields the full-scale shape 2^W.
- R3: The reference is floor(ipk·shape/2^W). The error is that reference minus the magnitude of the two's-complement leg sample, and the most negative sample has magnitude 2^(W-1).
- R4: The proportional term is floor(err·KP/2^SH) and the integral increment is floor(err·KI/2^SH), with floor rounding toward minus infinity. The candidate output is integrator + increment + proportional term + midpoint term.
- R5: A candidate below zero gives duty 0. A candidate above DMAX = 2^W − DMAX_GAP gives duty DMAX. Any other candidate is the duty word itself.
- R6: A leg's integrator takes its increment only in a period where its candidate lies inside [0, DMAX]. In a clamped period the integrator keeps its value.
- R7: The midpoint term floor(vmid·KM/2^SH), with vmid taken as a signed W-bit error, is added to every leg's candidate in the same period.
- R8: All inputs are captured on the accepted start edge. Start pulses and input changes while an update is in progress have no effect on the results, and they do not trigger another update.
- R9: Done is high for exactly one cycle, NCH·(2W+2) clock edges after the edge that accepted start.
- R10: Each leg uses only its own current sample, previous duty and integrator. A duty word changes only in the cycle its leg is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin one control-period update (accepted when idle) |
| cur_i | input | NCH*W | Signed leg-current samples, leg k at bits [k*W +: W] |
| ipk_i | input | W | Peak-current command (unsigned) |
| vhalf_i | input | W | Half of the DC output reference (unsigned) |
| vmax_i | input | W | Largest filtered input-voltage magnitude (unsigned) |
| vmid_i | input | W | Midpoint voltage error, signed |
| duty_o | output | NCH*W | Clamped duty words, unsigned fraction of 2^W, leg k at [k*W +: W] |
| done_o | output | 1 | One-cycle pulse when all legs are updated |

## Verification
A wrong integrator value does not show in the period where it arises. It appears in the duty of the same leg one period later, and the shape observer then feeds that duty into the next reference, so the error spreads across periods. Because of this the bench compares all six duties after every period against a running model. A wrong freeze decision shows up only when a leg leaves saturation, so saturation is always followed by a recovery phase. Divider or sequencing faults change the duty at once, or move the done pulse away from its fixed edge count.

// File: rtl/leg_current_pi.sv
module leg_current_pi #(
  parameter int W        = 16,
  parameter int NCH      = 6,
  parameter int SH       = 16,
  parameter int KP       = 328,
  parameter int KI       = 177,
  parameter int KM       = 131,
  parameter int DMAX_GAP = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NCH*W-1:0] cur_i,
  input  logic [W-1:0]     ipk_i,
  input  logic [W-1:0]     vhalf_i,
  input  logic [W-1:0]     vmax_i,
  input  logic [W-1:0]     vmid_i,
  output logic [NCH*W-1:0] duty_o,
  output logic             done_o
);

  localparam int CW   = 2*W + 8;
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CNTW = $clog2(2*W);
  localparam logic [W:0]             ONE      = {1'b1, {W{1'b0}}};
  localparam logic [W-1:0]           DMAX     = W'(ONE - (W+1)'(DMAX_GAP));
  localparam logic signed [CW-1:0]   KPC      = CW'(KP);
  localparam logic signed [CW-1:0]   KIC      = CW'(KI);
  localparam logic signed [CW-1:0]   KMC      = CW'(KM);
  localparam logic signed [CW-1:0]   DMAXC    = CW'(DMAX);
  localparam logic [CHW-1:0]         CH_LAST  = CHW'(NCH-1);
  localparam logic [CNTW-1:0]        CNT_LAST = CNTW'(2*W-1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV, S_UPD} st_t;
  st_t st;

  logic [CHW-1:0]   ch;
  logic [CNTW-1:0]  cnt;
  logic [NCH*W-1:0] cur_l;
  logic [W-1:0]     ipk_l, vhalf_l, vmax_l, vmid_l;
  logic [2*W-1:0]   num_q, quo_q;
  logic [W-1:0]     rem_q;
  logic [W-1:0]            duty_q [NCH];
  logic signed [CW-1:0]    acc_q  [NCH];

  logic [W:0]           onem, rem_sh, shape;
  logic [2*W:0]         num_full, ref_prod;
  logic                 ge, sat;
  logic [W-1:0]         ref_w, cur_w, mag, dnext;
  logic signed [CW-1:0] err, pterm, iterm, mterm, usum;

  assign onem     = ONE - {1'b0, duty_q[ch]};
  assign num_full = vhalf_l * onem;
  assign rem_sh   = {rem_q, num_q[2*W-1]};
  assign ge       = rem_sh >= {1'b0, vmax_l};

  assign shape    = (quo_q > (2*W)'(ONE)) ? ONE : quo_q[W:0];
  assign ref_prod = ipk_l * shape;
  assign ref_w    = ref_prod[2*W-1:W];
  assign cur_w    = cur_l[ch*W +: W];
  assign mag      = cur_w[W-1] ? (~cur_w + W'(1)) : cur_w;
  assign err      = $signed(CW'(ref_w)) - $signed(CW'(mag));
  assign pterm    = (err * KPC) >>> SH;
  assign iterm    = (err * KIC) >>> SH;
  assign mterm    = ($signed({{(CW-W){vmid_l[W-1]}}, vmid_l}) * KMC) >>> SH;
  assign usum     = acc_q[ch] + iterm + pterm + mterm;

  always_comb begin
    sat   = 1'b1;
    dnext = '0;
    if (usum < 0) begin
      dnext = '0;
    end else if (usum > DMAXC) begin
      dnext = DMAX;
    end else begin
      dnext = usum[W-1:0];
      sat   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ch      <= '0;
      cnt     <= '0;
      done_o  <= 1'b0;
      num_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      cur_l   <= '0;
      ipk_l   <= '0;
      vhalf_l <= '0;
      vmax_l  <= '0;
      vmid_l  <= '0;
      for (int k = 0; k < NCH; k++) begin
        duty_q[k] <= '0;
        acc_q[k]  <= '0;
      end
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          cur_l   <= cur_i;
          ipk_l   <= ipk_i;
          vhalf_l <= vhalf_i;
          vmax_l  <= vmax_i;
          vmid_l  <= vmid_i;
          ch      <= '0;
          st      <= S_LOAD;
        end
        S_LOAD: begin
          num_q <= num_full[2*W-1:0];
          quo_q <= '0;
          rem_q <= '0;
          cnt   <= '0;
          st    <= S_DIV;
        end
        S_DIV: begin
          rem_q <= ge ? W'(rem_sh - {1'b0, vmax_l}) : rem_sh[W-1:0];
          num_q <= {num_q[2*W-2:0], 1'b0};
          quo_q <= {quo_q[2*W-2:0], ge};
          if (cnt == CNT_LAST) st <= S_UPD;
          else cnt <= cnt + CNTW'(1);
        end
        S_UPD: begin
          duty_q[ch] <= dnext;
          if (!sat) acc_q[ch] <= acc_q[ch] + iterm;
          if (ch == CH_LAST) begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            ch <= ch + CHW'(1);
            st <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_out
    assign duty_o[k*W +: W] = duty_q[k];

    p_duty_bound_r5: assert property (@(posedge clk) disable iff (rst)
      duty_q[k] <= DMAX);

    p_acc_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      (st == S_UPD && ch == CHW'(k) && sat) |=> $stable(acc_q[k]));
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (duty_o == '0 && !done_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_src_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(st) == S_UPD && $past(ch) == CH_LAST));

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> ($stable(ipk_l) && $stable(vmid_l) && $stable(cur_l)
                        && $stable(vhalf_l) && $stable(vmax_l)));

  p_duty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st != S_UPD) |=> $stable(duty_o));

endmodule

// File: tb/leg_current_pi_tb.sv
module leg_current_pi_tb_top;
  localparam int W = 16, NCH = 6, SH = 16;
  localparam int KP = 20000, KI = 8000, KM = 16000;
  localparam longint DMAX = 65535;
  localparam int LAT = NCH * (2*W + 2);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [NCH*W-1:0] cur = '0;
  logic [W-1:0] ipk = '0, vhalf = '0, vmax = '0, vmid = '0;
  logic [NCH*W-1:0] duty;
  logic done;

  int n_cmp = 0, n_bad = 0;
  longint m_acc [NCH];
  longint m_duty[NCH];

  always #10 clk = ~clk;

  leg_current_pi #(.W(W), .NCH(NCH), .SH(SH), .KP(KP), .KI(KI), .KM(KM), .DMAX_GAP(1)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .cur_i(cur), .ipk_i(ipk), .vhalf_i(vhalf),
    .vmax_i(vmax), .vmid_i(vmid), .duty_o(duty), .done_o(done));

  task automatic cmp(input longint act, input longint exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic model_reset();
    for (int k = 0; k < NCH; k++) begin m_acc[k] = 0; m_duty[k] = 0; end
  endtask

  task automatic model_leg(input int k, input longint c, input longint ip, input longint vh,
                           input longint vm, input longint vd);
    longint num, q, shp, rf, mg, er, p, ii, md, u;
    num = vh * (65536 - m_duty[k]);
    q   = (vm == 0) ? 64'hFFFF_FFFF : num / vm;
    shp = (q > 65536) ? 65536 : q;
    rf  = (ip * shp) >>> 16;
    mg  = (c < 0) ? -c : c;
    er  = rf - mg;
    p   = (er * KP) >>> SH;
    ii  = (er * KI) >>> SH;
    md  = (vd * KM) >>> SH;
    u   = m_acc[k] + ii + p + md;
    if (u < 0) m_duty[k] = 0;
    else if (u > DMAX) m_duty[k] = DMAX;
    else begin m_duty[k] = u; m_acc[k] = m_acc[k] + ii; end
  endtask

  task automatic period(input longint c0, input longint c1, input longint c2, input longint c3,
                        input longint c4, input longint c5, input longint ip, input longint vh,
                        input longint vm, input longint vd, input bit busy_kick, input string tag);
    longint cs[NCH];
    int n;
    bit extra;
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3; cs[4] = c4; cs[5] = c5;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) cur[k*W +: W] = W'(cs[k]);
    ipk = W'(ip); vhalf = W'(vh); vmax = W'(vm); vmid = W'(vd);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (busy_kick && n == 50) begin
        start = 1'b1; ipk = 16'h1234; vmax = 16'h0003; vmid = 16'h8000; cur = ~cur;
      end
      if (busy_kick && n == 51) start = 1'b0;
    end
    cmp(n, LAT, {tag, " R9 done latency"});
    for (int k = 0; k < NCH; k++) model_leg(k, cs[k], ip, vh, vm, vd);
    for (int k = 0; k < NCH; k++)
      cmp(longint'(duty[k*W +: W]), m_duty[k], $sformatf("%s R10 leg %0d duty", tag, k));
    @(posedge clk); @(negedge clk);
    cmp(longint'(done), 0, {tag, " R9 done one cycle"});
    if (busy_kick) begin
      extra = 1'b0;
      for (int i = 0; i < 300; i++) begin @(posedge clk); @(negedge clk); if (done) extra = 1'b1; end
      cmp(longint'(extra), 0, {tag, " R8 busy start ignored"});
    end
  endtask

  function automatic longint srnd();
    return longint'($signed(16'($urandom())));
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp(longint'(duty), 0, "R1 reset duty");
    cmp(longint'(done), 0, "R1 reset done");
    rst = 1'b0;
    period(0, 0, 0, 0, 0, 0, 0, 20000, 40000, 0, 1'b0, "R1 zero error");
    period(100, -100, 200, -200, 300, -300, 30000, 20000, 0, 0, 1'b0, "R2 zero vmax");
    period(-32768, -32768, 0, 5, -32768, 32767, 65535, 16000, 30000, 0, 1'b0, "R3 extreme samples");
    for (int i = 0; i < 4; i++)
      period(10, 20, 30, 40, 50, 60, 65535, 30000, 20000, 20000, 1'b0, "R5 R6 high clamp");
    for (int i = 0; i < 3; i++)
      period(30000, -30000, 25000, -25000, 20000, -20000, 1000, 20000, 40000, 0, 1'b0, "R6 recovery");
    period(0, 0, 0, 0, 0, 0, 0, 20000, 40000, -32768, 1'b0, "R5 R7 low clamp");
    period(0, 0, 0, 0, 0, 0, 0, 20000, 40000, 12000, 1'b0, "R7 common offset");
    period(1000, 2000, 3000, 4000, 5000, 6000, 40000, 20000, 45000, 100, 1'b1, "R8 busy kick");
    for (int i = 0; i < 40; i++)
      period(srnd(), srnd(), srnd(), srnd(), srnd(), srnd(), longint'($urandom() & 32'hFFFF),
             8000 + longint'($urandom() % 16000), 20000 + longint'($urandom() % 45535),
             srnd(), 1'b0, "R4 random");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    cmp(longint'(duty), 0, "R1 reset after run");
    period(0, 0, 0, 0, 0, 0, 0, 20000, 40000, 0, 1'b0, "R1 integrators cleared");
    finish_run();
  end
endmodule